// File: doc/BRIEF.md
# Eight-Digit Display Driver Serializer

This block is the serial master for an external eight-digit seven-segment display driver. It talks to that chip over three wires: a frame-enable line that is low for the length of a frame, a bit clock, and a serial data line. Each transfer is a 16-bit frame. The upper byte holds a 4-bit register address with its top nibble zero. The lower byte holds the data. The frame is sent most significant bit first. The chip itself does the segment decoding. This block only moves words onto the wire.

Once reset is released, the block runs a built-in power-up script on its own. First it sets up the chip: decode mode, brightness, number of scanned digits, leaving shutdown, and leaving display test. Then it loads the eight digit registers with a counting pattern. After the script it raises `ready` and takes one write request at a time. A request is taken in a cycle where `wr_valid` and `ready` are both high. The address and data are captured in that cycle.

The bit-clock half-period is a whole number of system clocks, set by the parameter `HALF_DIV`.

Top module: `segdrv_serial_master`

## Requirements
- R1: A frame carries 16 bits, sent MSB first. Frame bits 15..12 are 0, bits 11..8 are the 4-bit address and bits 7..0 are the data byte.
- R2: `disp_load_n` falls before the first rising edge of `disp_sclk` in a frame. It rises only after the 16th rising edge. Exactly 16 rising edges of `disp_sclk` occur while it is low.
- R3: For each bit, `disp_sdo` is set first, then `disp_sclk` goes low, then high. `disp_sdo` does not change at a rising edge of `disp_sclk`. `disp_sclk` is never low while `disp_load_n` is high.
- R4: Every low phase of `disp_sclk` lasts exactly `HALF_DIV` system clock cycles.
- R5: While idle (and in reset), `disp_load_n` = 1, `disp_sclk` = 1 and `disp_sdo` = 0.
- R6: After reset, the first five frames are, as (address, data): (0x9,0xFF), (0xA,0x0F), (0xB,0x07), (0xC,0x01), (0xF,0x00).
- R7: The script then sends eight frames to addresses 0x1 through 0x8, with data 0x00 through 0x07 in that order.
- R8: `ready` is low in reset, during the whole script, and from the cycle after an accepted request until that frame has ended. It is high otherwise.
- R9: A `wr_valid` seen while `ready` is low is ignored and produces no frame.
- R10: The address and data are taken in the accepting cycle. Changes on `wr_addr`/`wr_data` after that do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request |
| wr_addr | input | 4 | Register address of the request |
| wr_data | input | 8 | Data byte of the request |
| ready | output | 1 | High when a request can be accepted |
| disp_load_n | output | 1 | Frame enable to the display chip, low during a frame |
| disp_sclk | output | 1 | Bit clock to the display chip; the chip samples on its rising edge |
| disp_sdo | output | 1 | Serial data to the display chip |

## Verification
The hardest case to reach is a request that arrives while `ready` is low. That happens both during the automatic power-up script and in the middle of a user frame. If such a request leaked through, the only sign would be one extra frame or a corrupted frame, much later. The stimulus therefore holds `wr_valid` high with junk values during the script and again during a user frame. It also changes the address and data buses right after an accepted request. A bench-side model of the display chip rebuilds every frame from the pins and matches it against a queue of expected words. An unexpected frame, or one with wrong content, shows up at once.

// File: rtl/segdrv_pkg.sv
`timescale 1ns/1ps
package segdrv_pkg;

  localparam int FRAME_BITS = 16;
  localparam int CFG_STEPS  = 5;
  localparam int DIGITS     = 8;
  localparam int SCRIPT_LEN = CFG_STEPS + DIGITS;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_SET,
    SH_LOW,
    SH_HIGH,
    SH_END
  } sh_state_t;

  // Build a frame word from a 4-bit address and a data byte.
  function automatic logic [FRAME_BITS-1:0] pack_frame(input logic [3:0] addr,
                                                       input logic [7:0] data);
    return {4'h0, addr, data};
  endfunction

  // Power-up script: five configuration writes, then the digit pattern.
  function automatic logic [FRAME_BITS-1:0] script_word(input int unsigned idx);
    logic [FRAME_BITS-1:0] w;
    case (idx)
      0: w = pack_frame(4'h9, 8'hFF);
      1: w = pack_frame(4'hA, 8'h0F);
      2: w = pack_frame(4'hB, 8'h07);
      3: w = pack_frame(4'hC, 8'h01);
      4: w = pack_frame(4'hF, 8'h00);
      default: w = pack_frame(4'(idx - CFG_STEPS + 1), 8'(idx - CFG_STEPS));
    endcase
    return w;
  endfunction

endpackage

// File: rtl/segdrv_frame_shifter.sv
`timescale 1ns/1ps
module segdrv_frame_shifter
  import segdrv_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] word,
  output logic                  busy,
  output logic                  done,
  output logic                  load_n,
  output logic                  sclk,
  output logic                  sdo
);

  localparam int CNT_W = $clog2(HALF_DIV + 1);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  sh_state_t             st;
  logic [CNT_W-1:0]      cnt;
  logic [BIT_W-1:0]      bitn;
  logic [FRAME_BITS-1:0] shreg;
  logic                  phase_end;

  assign phase_end = (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SH_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else if (st == SH_IDLE) begin
      if (start) begin
        shreg <= word;
        bitn  <= '0;
        cnt   <= '0;
        st    <= SH_SET;
      end
    end else if (phase_end) begin
      cnt <= '0;
      case (st)
        SH_SET:  st <= SH_LOW;
        SH_LOW:  st <= SH_HIGH;
        SH_HIGH: begin
          if (bitn == BIT_LAST) begin
            st <= SH_END;
          end else begin
            bitn  <= bitn + 1'b1;
            shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
            st    <= SH_SET;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign busy   = (st != SH_IDLE);
  assign done   = (st == SH_END) && phase_end;
  assign load_n = (st == SH_IDLE) || (st == SH_END);
  assign sclk   = (st != SH_LOW);
  assign sdo    = (st == SH_SET || st == SH_LOW || st == SH_HIGH) ? shreg[FRAME_BITS-1] : 1'b0;

  assert_sclk_framed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> !load_n);

  assert_sdo_stable_at_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdo));

  assert_no_start_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(shreg));

endmodule

// File: rtl/segdrv_init_seq.sv
`timescale 1ns/1ps
module segdrv_init_seq
  import segdrv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sh_busy,
  input  logic                  sh_done,
  output logic                  running,
  output logic                  issue,
  output logic [FRAME_BITS-1:0] word
);

  localparam int IDX_W = $clog2(SCRIPT_LEN + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(SCRIPT_LEN);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (running && sh_done) begin
      idx <= idx + 1'b1;
    end
  end

  assign running = (idx != IDX_END);
  assign issue   = running && !sh_busy;
  assign word    = script_word(32'(idx));

  assert_script_ends_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !running);

endmodule

// File: rtl/segdrv_serial_master.sv
`timescale 1ns/1ps
module segdrv_serial_master
  import segdrv_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       ready,
  output logic       disp_load_n,
  output logic       disp_sclk,
  output logic       disp_sdo
);

  logic                  sh_busy;
  logic                  sh_done;
  logic                  sh_start;
  logic [FRAME_BITS-1:0] sh_word;
  logic                  scr_running;
  logic                  scr_issue;
  logic [FRAME_BITS-1:0] scr_word;
  logic                  user_accept;

  segdrv_init_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .sh_busy (sh_busy),
    .sh_done (sh_done),
    .running (scr_running),
    .issue   (scr_issue),
    .word    (scr_word)
  );

  assign ready       = !scr_running && !sh_busy;
  assign user_accept = wr_valid && ready;
  assign sh_start    = scr_issue || user_accept;
  assign sh_word     = scr_running ? scr_word : pack_frame(wr_addr, wr_data);

  segdrv_frame_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (sh_start),
    .word   (sh_word),
    .busy   (sh_busy),
    .done   (sh_done),
    .load_n (disp_load_n),
    .sclk   (disp_sclk),
    .sdo    (disp_sdo)
  );

  assert_idle_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (disp_load_n && disp_sclk && !disp_sdo));

  assert_accept_drops_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    user_accept |=> !ready);

  assert_frame_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    user_accept |=> !disp_load_n);

endmodule

// File: tb/segdrv_serial_master_tb_top.sv
`timescale 1ns/1ps
module segdrv_serial_master_tb_top;

  localparam int H = 4;
  localparam int CLK_NS = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       ready;
  logic       disp_load_n;
  logic       disp_sclk;
  logic       disp_sdo;

  always #(CLK_NS/2) clk = ~clk;

  segdrv_serial_master #(.HALF_DIV(H)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .ready       (ready),
    .disp_load_n (disp_load_n),
    .disp_sclk   (disp_sclk),
    .disp_sdo    (disp_sdo)
  );

  int n_vec = 0;
  int n_bad = 0;
  int frames = 0;
  logic mon_en = 1'b0;
  logic [15:0] expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // display chip model: shifts on rising sclk while frame enable is low
  logic [15:0] rx;
  int rx_bits;
  realtime fall_t;

  always @(negedge disp_load_n) begin
    rx_bits = 0;
    rx = '0;
  end

  always @(posedge disp_sclk) begin
    if (mon_en && disp_load_n === 1'b0) begin
      rx = {rx[14:0], disp_sdo};
      rx_bits++;
      chk(($realtime - fall_t) == real'(H * CLK_NS), "R4 low phase ns",
          int'($realtime - fall_t), H * CLK_NS);
    end
  end

  always @(negedge disp_sclk) begin
    if (mon_en) begin
      fall_t = $realtime;
      chk(disp_load_n === 1'b0, "R3 sclk low inside frame", int'(disp_load_n), 0);
    end
  end

  always @(posedge disp_load_n) begin
    if (mon_en) begin
      frames++;
      chk(rx_bits == 16, "R2 rising edges per frame", rx_bits, 16);
      if (expq.size() == 0) begin
        chk(1'b0, "R9 unexpected frame", int'(rx), 0);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(rx == e, "R1 R6 R7 R10 frame content", int'(rx), int'(e));
      end
    end
  end

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    while (ready !== 1'b1) @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    expq.push_back({4'h0, a, d});
    @(negedge clk);
    wr_valid = 1'b0;
    chk(ready == 1'b0, "R8 ready drops after accept", int'(ready), 0);
  endtask

  task automatic wait_ready();
    while (ready !== 1'b1) @(negedge clk);
  endtask

  initial begin
    #(200000 * CLK_NS);
    chk(1'b0, "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] cfg_a [5] = '{4'h9, 4'hA, 4'hB, 4'hC, 4'hF};
    logic [7:0] cfg_d [5] = '{8'hFF, 8'h0F, 8'h07, 8'h01, 8'h00};
    rst_n = 1'b0;
    wr_valid = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    for (int i = 0; i < 5; i++) expq.push_back({4'h0, cfg_a[i], cfg_d[i]});   // R6
    for (int k = 0; k < 8; k++) expq.push_back({4'h0, 4'(k + 1), 8'(k)});      // R7
    repeat (5) @(negedge clk);
    chk(disp_load_n == 1'b1, "R5 reset load", int'(disp_load_n), 1);
    chk(disp_sclk == 1'b1, "R5 reset sclk", int'(disp_sclk), 1);
    chk(disp_sdo == 1'b0, "R5 reset sdo", int'(disp_sdo), 0);
    chk(ready == 1'b0, "R8 reset ready", int'(ready), 0);
    mon_en = 1'b1;
    rst_n = 1'b1;

    // R9: junk requests during the script
    wr_valid = 1'b1;
    wr_addr = 4'h6;
    wr_data = 8'hEE;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      chk(ready == 1'b0, "R8 ready low in script", int'(ready), 0);
    end
    wr_valid = 1'b0;

    wait_ready();
    chk(frames == 13, "R6 R7 script frame count", frames, 13);
    chk(expq.size() == 0, "R7 script all sent", expq.size(), 0);
    chk(disp_load_n && disp_sclk && !disp_sdo, "R5 idle levels after script",
        {disp_load_n, disp_sclk, disp_sdo}, 3'b110);

    // R10: change buses right after acceptance, R9: junk valid mid-frame
    do_write(4'h3, 8'h5A);
    wr_addr = 4'hC;
    wr_data = 8'h33;
    wr_valid = 1'b1;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      chk(ready == 1'b0, "R8 ready low mid-frame", int'(ready), 0);
    end
    wr_valid = 1'b0;
    wait_ready();
    chk(frames == 14, "R9 R10 single frame", frames, 14);

    do_write(4'h0, 8'h00);
    do_write(4'hF, 8'hFF);
    do_write(4'h8, 8'h81);
    do_write(4'h1, 8'h01);
    wait_ready();
    @(negedge clk);
    chk(frames == 18, "R1 total frames", frames, 18);
    chk(expq.size() == 0, "R1 queue drained", expq.size(), 0);
    chk(disp_load_n && disp_sclk && !disp_sdo, "R5 idle levels at end",
        {disp_load_n, disp_sclk, disp_sdo}, 3'b110);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule